// File: doc/BRIEF.md
# Two-Input Handshake Join Stage

This stage merges two independent valid/ready streams into a single registered valid/ready stream. The two producers may offer their operands in different cycles. The stage holds off both of them until each one has an operand waiting, then takes the two together in one cycle. It combines the pair with a selectable operation and stores the result in a one-entry output register, which drives the downstream handshake.

The output register can take a new result in two cases: when it is empty, or when its current result leaves in the same cycle. While downstream applies back-pressure, the stored result stays frozen and both inputs are held off. With both inputs continuously valid and downstream continuously ready, the stage delivers one result per clock.

Top module: `hs_join2`

## Requirements
- R1: An input is consumed only together with the other input: in every cycle, `a_valid && a_ready` is true exactly when `b_valid && b_ready` is true.
- R2: `a_ready` equals `b_valid && (y_ready || !y_valid)`, and `b_ready` equals `a_valid && (y_ready || !y_valid)`. An input's own valid never raises its own ready, and an input that is valid alone is never accepted.
- R3: In the cycle after a pair is consumed, `y_valid` is 1. In the cycle after a result leaves (`y_valid && y_ready`) with no pair consumed, `y_valid` is 0.
- R4: While `y_valid` is 1 and `y_ready` is 0, `y_valid` and `y_data` stay unchanged into the next cycle.
- R5: `y_data` changes only in the cycle after a pair is consumed.
- R6: While `rst_n` is low, `y_valid` and `y_data` are zero, asynchronously.
- R7: With the default operation (`OP = 0`), each result is `(a_data + b_data) mod 2**W` of the pair consumed together. Results leave in the order their pairs were consumed.
- R8: With both inputs valid and `y_ready` high in every cycle, a new result leaves in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | First operand offered |
| a_ready | output | 1 | First operand taken this cycle if valid |
| a_data | input | W | First operand |
| b_valid | input | 1 | Second operand offered |
| b_ready | output | 1 | Second operand taken this cycle if valid |
| b_data | input | W | Second operand |
| y_valid | output | 1 | Result register holds a result |
| y_ready | input | 1 | Downstream accepts the result |
| y_data | output | W | Registered result |

## Verification
The embedded assertions check the following on every clock:
- paired consumption (R1);
- the ready conditions, including refusal of a lone valid (R2);
- the valid transitions after a pair is consumed or a result leaves (R3);
- freezing of the result under stall (R4);
- the load-only-on-transfer rule (R5);
- the reset values (R6).

The arithmetic result and its ordering against the pairs the producers offered (R7), and the sustained one-per-cycle rate (R8), depend on stimulus history. Only the bench's scoreboard can show them, using its overflow, back-to-back and random-gap scenarios.

// File: rtl/hs_join2.sv
module hs_join2 #(
  parameter int W  = 16,
  parameter int OP = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] a_data,
  input  logic         b_valid,
  output logic         b_ready,
  input  logic [W-1:0] b_data,
  output logic         y_valid,
  input  logic         y_ready,
  output logic [W-1:0] y_data
);

  logic         slot_free;
  logic         take;
  logic [W-1:0] comb_res;

  assign slot_free = y_ready || !y_valid;
  assign a_ready   = b_valid && slot_free;
  assign b_ready   = a_valid && slot_free;
  assign take      = a_valid && b_valid && slot_free;

  generate
    if (OP == 1) begin : g_xor
      assign comb_res = a_data ^ b_data;
    end else if (OP == 2) begin : g_max
      assign comb_res = (a_data > b_data) ? a_data : b_data;
    end else begin : g_sum
      assign comb_res = a_data + b_data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_valid <= 1'b0;
    else        y_valid <= take || (y_valid && !y_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y_data <= '0;
    else if (take) y_data <= comb_res;
  end

  a_r1_paired: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) == (b_valid && b_ready));

  a_r2_lone_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_valid |-> !a_ready) and (!a_valid |-> !b_ready));

  a_r2_accept_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && y_ready) |-> (a_ready && b_ready));

  a_r3_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) |=> y_valid);

  a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && y_ready && !(a_valid && a_ready)) |=> !y_valid);

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data)));

  a_r5_load_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && a_ready) |=> $stable(y_data));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r6_reset_clear: assert (!y_valid && y_data == '0);
    end
  end

endmodule

// File: tb/test_hs_join2.sv
`timescale 1ns/1ps
module test_hs_join2;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_valid = 1'b0, b_valid = 1'b0, y_ready = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic         a_ready, b_ready, y_valid;
  logic [W-1:0] y_data;

  int n_chk = 0, n_bad = 0;
  int n_out = 0;
  logic [W-1:0] q[$];

  always #2.5 clk = ~clk;

  hs_join2 #(.W(W)) i_hs_join2 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // inputs already driven; compare, then advance model across one posedge
  task automatic step();
    logic mv, free, tk;
    #1;
    mv   = (q.size() != 0);
    free = y_ready || !mv;
    tk   = a_valid && b_valid && free;
    chk("R2 a_ready", W'(a_ready), W'(b_valid && free));
    chk("R2 b_ready", W'(b_ready), W'(a_valid && free));
    chk("R1 pairing", W'(a_valid && a_ready), W'(b_valid && b_ready));
    chk("R3 y_valid", W'(y_valid), W'(mv));
    if (mv) chk("R7 y_data", y_data, q[0]);
    if (mv && y_ready) begin q.pop_front(); n_out++; end
    if (tk) q.push_back(a_data + b_data);
    @(posedge clk);
    @(negedge clk);
  endtask

  // random driver honouring hold-while-not-taken
  task automatic rand_cycles(input int n, input int pa, input int pb, input int pr);
    for (int i = 0; i < n; i++) begin
      logic took;
      took = a_valid && a_ready;
      if (!a_valid || took) begin
        a_valid = ($urandom % 100) < pa;
        a_data  = W'($urandom);
      end
      if (!b_valid || took) begin
        b_valid = ($urandom % 100) < pb;
        b_data  = W'($urandom);
      end
      y_ready = ($urandom % 100) < pr;
      step();
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset valid", W'(y_valid), '0);
    chk("R6 reset data", y_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: lone a valid for several cycles, nothing consumed
    a_valid = 1; a_data = 16'h1234; y_ready = 1;
    repeat (4) step();
    chk("R2 lone a no output", W'(y_valid), '0);

    // pair arrives; R7 overflow wraps
    a_data = 16'hFFFF; b_valid = 1; b_data = 16'h0002;
    step();
    a_valid = 0; b_valid = 0;
    // R4 stall: hold several cycles
    y_ready = 0;
    repeat (5) step();
    chk("R4 held valid", W'(y_valid), 1);
    chk("R7 wrap sum", y_data, 16'h0001);
    // stalled with both inputs valid: not taken
    a_valid = 1; b_valid = 1; a_data = 16'h0010; b_data = 16'h0020;
    repeat (3) step();
    chk("R4 data frozen", y_data, 16'h0001);
    y_ready = 1;
    step(); step();
    chk("R5 loaded next pair", y_data, 16'h0030);
    a_valid = 0; b_valid = 0;
    step(); step();
    chk("R3 drained", W'(y_valid), '0);

    // R8 back-to-back throughput
    begin
      int start;
      start = n_out;
      a_valid = 1; b_valid = 1; y_ready = 1;
      for (int i = 0; i < 20; i++) begin
        a_data = W'(i * 7); b_data = W'(i * 3 + 1);
        step();
      end
      a_valid = 0; b_valid = 0;
      step();
      chk("R8 one per cycle", W'(n_out - start), W'(20));
    end

    // random gaps and stalls
    rand_cycles(1500, 60, 45, 70);
    rand_cycles(1500, 90, 90, 30);
    rand_cycles(500, 100, 100, 100);

    // R6 async reset mid-stream
    a_valid = 1; b_valid = 1; y_ready = 0; a_data = 5; b_data = 6;
    step();
    #1 rst_n = 0;
    #1;
    chk("R6 async valid", W'(y_valid), '0);
    chk("R6 async data", y_data, '0);
    q.delete();
    a_valid = 0; b_valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rand_cycles(500, 70, 70, 60);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule